// File: doc/BRIEF.md
# Lockable Victim-Pointer Translation Cache

This block is the translation cache of a device-side memory management unit. It keeps a small, fully associative set of address mappings (8 or 32 entries, chosen by a parameter). Each mapping pairs a tag word with a data word. The tag word holds a virtual page tag, a page-size code, a keep-resident flag and a valid bit. The data word holds a physical base and attribute bits. Four page sizes can sit side by side in the cache: 4 KB, 64 KB, 1 MB and 16 MB. A lookup matches any entry whose address range covers the incoming address.

Software fills and maintains the cache through a narrow register port. It stages a tag word and a data word, then issues a load command. Replacement is steered by a lock register with two fields. The victim field chooses the slot that the next ordinary load writes. The base field marks how many low slots are kept resident. Those kept slots are never picked again as the victim pointer wraps around. Other commands remove one range, flush the whole cache, or read back the entry that the victim field selects. A separate lookup port accepts a 32-bit device address every cycle and returns a hit flag and the translated physical address one cycle later.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid, the base and victim fields are zero, and the lookup port reports a miss with a zero physical address.
- R2: Register select 0 is the lock register. Its base field is at bits 14:10 and its victim field is at bits 8:4. A write takes the low log2(ENTRIES) bits of each field. All other bits read as zero.
- R3: A load command (select 3) writes the staged tag word (select 1) and the staged data word (select 2) into one slot and sets that slot's valid bit. The tag layout is: bits 31:12 virtual tag, bit 3 keep-resident flag, bit 2 valid, bits 1:0 size code. Read-tag (select 6) and read-data (select 7) return the slot that the victim field selects, with bit 2 showing its current valid state.
- R4: An ordinary load (flag clear) writes the slot at the victim index and then advances the victim by one. When the victim reaches ENTRIES it wraps to the current base, not to zero.
- R5: A keep-resident load (tag bit 3 set) writes the slot at the base index and increments the base. The victim then equals the new base, or zero once the base has reached ENTRIES.
- R6: When the base equals ENTRIES, any load is refused. No entry, valid bit or pointer changes.
- R7: A global flush (select 5) clears every valid bit and sets both the base and the victim to zero.
- R8: Size code 0, 1, 2 and 3 means 4 KB, 64 KB, 1 MB and 16 MB. A valid entry hits when the lookup address lies in the range from its size-aligned tag address up to, but not including, that address plus the page size. The physical address is the data word's bits above the page offset joined with the address's offset bits.
- R9: When several entries hit, the lowest index supplies the result.
- R10: A flush-entry command (select 4) invalidates every valid entry whose range covers the address in the staged tag (bits 31:12, low bits taken as zero). If no entry matches, nothing changes.
- R11: The lookup result appears in the cycle after the address is presented. A miss reports hit low and a physical address of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe; a write to a command select triggers that command |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for the current select |
| lk_addr | input | 32 | Device address to translate |
| lk_hit | output | 1 | Registered hit flag for the previous cycle's address |
| lk_pa | output | 32 | Registered physical address, zero on a miss |

## Verification
The hardest state to reach from the ports is a cache whose every slot is kept resident. The bench gets there by issuing one keep-resident load for each slot, each with a distinct tag and data word. It then tries both an ordinary load and a keep-resident load. It confirms that neither new mapping becomes visible and that the first and last resident mappings still translate. Victim wrap-around to a nonzero base is reached differently: the bench writes the lock register directly, placing the victim one slot below the end.

// File: rtl/xlat_pkg.sv
// Shared definitions for the translation cache.
// Assumes 32-bit device and physical addresses.
package xlat_pkg;

    typedef enum logic [2:0] {
        SEL_LOCK      = 3'd0,
        SEL_STG_TAG   = 3'd1,
        SEL_STG_DATA  = 3'd2,
        SEL_LOAD      = 3'd3,
        SEL_FLUSH_ONE = 3'd4,
        SEL_FLUSH_ALL = 3'd5,
        SEL_RD_TAG    = 3'd6,
        SEL_RD_DATA   = 3'd7
    } reg_sel_e;

    localparam int LOCK_BASE_LSB = 10;
    localparam int LOCK_VICT_LSB = 4;
    localparam int TAG_KEEP_BIT  = 3;
    localparam int TAG_VALID_BIT = 2;

    // Mask of page-number bits for a size code (0:4K 1:64K 2:1M 3:16M).
    function automatic logic [31:0] page_mask(input logic [1:0] code);
        case (code)
            2'd0:    page_mask = 32'hFFFF_F000;
            2'd1:    page_mask = 32'hFFFF_0000;
            2'd2:    page_mask = 32'hFFF0_0000;
            default: page_mask = 32'hFF00_0000;
        endcase
    endfunction

endpackage

// File: rtl/xlat_range_match.sv
// Range comparator for one cache entry.
// Hits when the entry is valid and the address falls inside the page that
// its tag describes. Assumes tags are interpreted size-aligned.
module xlat_range_match
    import xlat_pkg::*;
(
    input  logic [31:0] tag_word,
    input  logic        entry_valid,
    input  logic [31:0] addr,
    output logic        hit
);
    logic [31:0] mask;

    // Size-masked compare equals start <= addr < start + size.
    always_comb begin
        mask = page_mask(tag_word[1:0]);
        hit  = entry_valid && ((addr & mask) == (tag_word & mask));
    end

endmodule

// File: rtl/xlat_lowest_pick.sv
// Fixed-priority selector: the lowest set bit of the hit vector wins.
// Assumes N is at least 2.
module xlat_lowest_pick #(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  hit_vec,
    output logic          any_hit,
    output logic [IW-1:0] win_idx
);
    logic [N-1:0] below_win;

    // Scan from the top down so the lowest hit overrides.
    always_comb begin
        any_hit = 1'b0;
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                any_hit = 1'b1;
                win_idx = IW'(i);
            end
        end
    end

    // Guard: the winner hits and nothing below it hits.
    always_comb begin
        below_win = (N'(1) << win_idx) - N'(1);
        AST_PICK_LOWEST: assert (!any_hit || (hit_vec[win_idx] && ((hit_vec & below_win) == '0))) // R9
            else $error("pick not lowest");
    end

endmodule

// File: rtl/xlat_lock_ctrl.sv
// Base/victim pointer control for the translation cache.
// Chooses the slot for each load, advances the pointers, refuses loads once
// every slot is kept resident. Assumes at most one command per cycle.
module xlat_lock_ctrl
    import xlat_pkg::*;
#(
    parameter int N  = 32,
    localparam int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lock_we,
    input  logic [31:0]   lock_wdata,
    input  logic          load_cmd,
    input  logic          load_keep,
    input  logic          flush_all,
    output logic [IW:0]   base_q,
    output logic [IW-1:0] victim_q,
    output logic          load_go,
    output logic [IW-1:0] load_idx
);
    localparam logic [IW:0] FULL = (IW+1)'(N);

    logic [IW:0] base_inc;
    logic [IW:0] vict_inc;

    // Accept a load only while a replaceable slot remains.
    always_comb begin
        load_go  = load_cmd && (base_q != FULL);
        load_idx = load_keep ? base_q[IW-1:0] : victim_q;
        base_inc = base_q + 1'b1;
        vict_inc = {1'b0, victim_q} + 1'b1;
    end

    // Pointer update on flush, lock write or accepted load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q   <= '0;
            victim_q <= '0;
        end else if (flush_all) begin
            base_q   <= '0;
            victim_q <= '0;
        end else if (lock_we) begin
            base_q   <= {1'b0, lock_wdata[LOCK_BASE_LSB +: IW]};
            victim_q <= lock_wdata[LOCK_VICT_LSB +: IW];
        end else if (load_go) begin
            if (load_keep) begin
                base_q   <= base_inc;
                victim_q <= (base_inc == FULL) ? '0 : base_inc[IW-1:0];
            end else begin
                victim_q <= (vict_inc == FULL) ? base_q[IW-1:0] : vict_inc[IW-1:0];
            end
        end
    end

    AST_BASE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        base_q <= FULL) else $error("base past end"); // R5
    AST_FLUSH_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (base_q == '0 && victim_q == '0)) else $error("flush ptrs"); // R7
    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_cmd && base_q == FULL) |=> ($stable(base_q) && $stable(victim_q))) else $error("full load moved"); // R6
    AST_VICT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_go && !load_keep && victim_q != IW'(N-1)) |=> victim_q == $past(victim_q) + 1'b1) else $error("victim step"); // R4
    AST_VICT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (load_go && !load_keep && victim_q == IW'(N-1)) |=> victim_q == $past(base_q[IW-1:0])) else $error("victim wrap"); // R4
    AST_KEEP_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_go && load_keep) |=> base_q == $past(base_q) + 1'b1) else $error("base step"); // R5

endmodule

// File: rtl/xlat_cache.sv
// Fully associative translation cache with a lockable victim pointer.
// Holds ENTRIES mappings (8 or 32). Software maintains them via the
// register port; the lookup port translates one address per cycle with
// one cycle of latency. Assumes a single register command per cycle.
module xlat_cache
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [2:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic [31:0] lk_addr,
    output logic        lk_hit,
    output logic [31:0] lk_pa
);
    localparam int IW = $clog2(ENTRIES);

    logic [31:0]        tag_mem  [ENTRIES];
    logic [31:0]        data_mem [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [31:0]        stg_tag;
    logic [31:0]        stg_data;

    logic wr_lock, wr_tag, wr_data, cmd_load, cmd_flush_one, cmd_flush_all;
    logic [IW:0]        base_q;
    logic [IW-1:0]      victim_q;
    logic               load_go;
    logic [IW-1:0]      load_idx;
    logic [ENTRIES-1:0] lk_vec;
    logic [ENTRIES-1:0] fl_vec;
    logic               lk_any;
    logic [IW-1:0]      lk_idx;
    logic [31:0]        fl_addr;
    logic [31:0]        win_mask;
    logic               lk_hit_q;
    logic [31:0]        lk_pa_q;

    // Decode register writes into staging writes and commands.
    always_comb begin
        wr_lock       = reg_we && (reg_sel == SEL_LOCK);
        wr_tag        = reg_we && (reg_sel == SEL_STG_TAG);
        wr_data       = reg_we && (reg_sel == SEL_STG_DATA);
        cmd_load      = reg_we && (reg_sel == SEL_LOAD);
        cmd_flush_one = reg_we && (reg_sel == SEL_FLUSH_ONE);
        cmd_flush_all = reg_we && (reg_sel == SEL_FLUSH_ALL);
        fl_addr       = {stg_tag[31:12], 12'h000};
    end

    // Staging registers for the next load or range flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_tag  <= '0;
            stg_data <= '0;
        end else begin
            if (wr_tag)  stg_tag  <= reg_wdata;
            if (wr_data) stg_data <= reg_wdata;
        end
    end

    xlat_lock_ctrl #(.N(ENTRIES)) u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .lock_we    (wr_lock),
        .lock_wdata (reg_wdata),
        .load_cmd   (cmd_load),
        .load_keep  (stg_tag[TAG_KEEP_BIT]),
        .flush_all  (cmd_flush_all),
        .base_q     (base_q),
        .victim_q   (victim_q),
        .load_go    (load_go),
        .load_idx   (load_idx)
    );

    // One lookup comparator and one flush comparator per entry.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        xlat_range_match u_lk (
            .tag_word    (tag_mem[g]),
            .entry_valid (valid_q[g]),
            .addr        (lk_addr),
            .hit         (lk_vec[g])
        );
        xlat_range_match u_fl (
            .tag_word    (tag_mem[g]),
            .entry_valid (valid_q[g]),
            .addr        (fl_addr),
            .hit         (fl_vec[g])
        );
    end

    xlat_lowest_pick #(.N(ENTRIES)) u_pick (
        .hit_vec (lk_vec),
        .any_hit (lk_any),
        .win_idx (lk_idx)
    );

    // Entry storage: load, range flush and global flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                tag_mem[i]  <= '0;
                data_mem[i] <= '0;
            end
        end else if (cmd_flush_all) begin
            valid_q <= '0;
        end else if (load_go) begin
            tag_mem[load_idx]  <= stg_tag;
            data_mem[load_idx] <= stg_data;
            valid_q[load_idx]  <= 1'b1;
        end else if (cmd_flush_one) begin
            valid_q <= valid_q & ~fl_vec;
        end
    end

    // Registered lookup result; zero address on a miss.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit_q <= 1'b0;
            lk_pa_q  <= '0;
        end else begin
            lk_hit_q <= lk_any;
            lk_pa_q  <= lk_any ? ((data_mem[lk_idx] & win_mask) | (lk_addr & ~win_mask)) : '0;
        end
    end

    // Page mask of the winning entry.
    always_comb win_mask = page_mask(tag_mem[lk_idx][1:0]);

    // Read mux for software.
    always_comb begin
        reg_rdata = '0;
        case (reg_sel)
            SEL_LOCK: begin
                reg_rdata[LOCK_BASE_LSB +: IW] = base_q[IW-1:0];
                reg_rdata[LOCK_VICT_LSB +: IW] = victim_q;
            end
            SEL_STG_TAG:  reg_rdata = stg_tag;
            SEL_STG_DATA: reg_rdata = stg_data;
            SEL_RD_TAG:   reg_rdata = {tag_mem[victim_q][31:3], valid_q[victim_q], tag_mem[victim_q][1:0]};
            SEL_RD_DATA:  reg_rdata = data_mem[victim_q];
            default:      reg_rdata = '0;
        endcase
    end

    assign lk_hit = lk_hit_q;
    assign lk_pa  = lk_pa_q;

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> lk_pa == '0) else $error("miss with address"); // R11
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_flush_all |=> valid_q == '0) else $error("flush left valid"); // R7
    AST_LOAD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        load_go |=> valid_q[$past(load_idx)]) else $error("load not valid"); // R3
    AST_RANGE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_flush_one |=> (valid_q & $past(fl_vec)) == '0) else $error("range flush"); // R10
    AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_load && !load_go) |=> $stable(valid_q)) else $error("refused load wrote"); // R6

endmodule

// File: tb/xlat_cache_bench.sv
`timescale 1ns/1ps
module xlat_cache_bench;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] lk_addr = '0;
    logic        lk_hit;
    logic [31:0] lk_pa;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    xlat_cache #(.ENTRIES(N)) u_xlat_cache (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_pa(lk_pa)
    );

    // Lookup vectors {address, expected hit, expected physical address}.
    localparam logic [95:0] LK_VEC [0:8] = '{
        {32'h0001_2345, 32'd1, 32'h8000_2345},
        {32'h0001_3456, 32'd1, 32'h8000_3456},
        {32'h0010_ABCD, 32'd1, 32'h9000_ABCD},
        {32'h001F_FFFF, 32'd1, 32'h900F_FFFF},
        {32'h0020_0000, 32'd0, 32'h0000_0000},
        {32'h02FF_FFFF, 32'd1, 32'hA0FF_FFFF},
        {32'h0300_0000, 32'd0, 32'h0000_0000},
        {32'h0000_FFFF, 32'd0, 32'h0000_0000},
        {32'h0002_0000, 32'd0, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic look(input logic [31:0] a, output logic h, output logic [31:0] pa);
        @(negedge clk);
        lk_addr = a;
        @(posedge clk); #1;
        h = lk_hit; pa = lk_pa;
    endtask

    task automatic load(input logic [31:0] t, input logic [31:0] d);
        wr(3'd1, t);
        wr(3'd2, d);
        wr(3'd3, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        logic h;
        logic [31:0] pa;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); check("R1 lock", v, 32'h0);
        rd(3'd6, v); check("R1 rdtag", v, 32'h0);
        look(32'h0000_0000, h, pa); check("R1 hit", {31'd0, h}, 32'd0); check("R1 pa", pa, 32'h0);

        // R2 lock fields
        wr(3'd0, 32'hFFFF_FFFF);
        rd(3'd0, v); check("R2 lock fields", v, 32'h0000_7DF0);
        // R7 global flush clears pointers
        wr(3'd5, 32'h0);
        rd(3'd0, v); check("R7 ptrs", v, 32'h0);

        // Ordinary loads
        load(32'h0001_0001, 32'h8000_0025);
        load(32'h0010_0002, 32'h9000_0000);
        load(32'h0200_0003, 32'hA000_0000);
        load(32'h0001_3000, 32'hB000_1000);
        rd(3'd0, v); check("R4 victim after 4 loads", v, 32'h0000_0040);
        wr(3'd0, 32'h0000_0030);
        rd(3'd6, v); check("R3 rdtag", v, 32'h0001_3004);
        rd(3'd7, v); check("R3 rddata", v, 32'hB000_1000);

        // R8/R9/R11 lookup table
        for (int k = 0; k < 9; k++) begin
            look(LK_VEC[k][95:64], h, pa);
            check("R8 R9 R11 hit", {31'd0, h}, LK_VEC[k][63:32]);
            check("R8 R9 R11 pa", pa, LK_VEC[k][31:0]);
        end

        // R10 range flush covering two entries
        wr(3'd1, 32'h0001_3000);
        wr(3'd4, 32'h0);
        look(32'h0001_3456, h, pa); check("R10 flushed hit", {31'd0, h}, 32'd0);
        rd(3'd6, v); check("R10 slot3 invalid", v, 32'h0001_3000);
        wr(3'd1, 32'h0500_0000);
        wr(3'd4, 32'h0);
        look(32'h02FF_FFFF, h, pa); check("R10 no-match keeps", pa, 32'hA0FF_FFFF);

        // R7 flush empties cache
        wr(3'd5, 32'h0);
        look(32'h0010_0000, h, pa); check("R7 empty", {31'd0, h}, 32'd0);

        // R4 wrap to nonzero base
        wr(3'd0, (32'd2 << 10) | (32'd30 << 4));
        load(32'h0300_0000, 32'h1);
        load(32'h0300_1000, 32'h2);
        rd(3'd0, v); check("R4 wrap to base", v, 32'h0000_0820);

        // R5 keep-resident load
        wr(3'd5, 32'h0);
        load(32'h0400_0008, 32'hD000_0000);
        rd(3'd0, v); check("R5 base/victim", v, 32'h0000_0410);
        wr(3'd0, 32'h0000_0400);
        rd(3'd6, v); check("R5 stored at base", v, 32'h0400_000C);

        // R6 fill all slots resident, then refuse loads
        wr(3'd5, 32'h0);
        for (int i = 0; i < N; i++)
            load((32'(i) << 12) | 32'h8, 32'hC000_0000 | (32'(i) << 12));
        load(32'h7770_0000, 32'h1234_5000);
        load(32'h8880_0008, 32'h5678_9000);
        look(32'h7770_0000, h, pa); check("R6 ordinary refused", {31'd0, h}, 32'd0);
        look(32'h8880_0000, h, pa); check("R6 resident refused", {31'd0, h}, 32'd0);
        look(32'h0000_0ABC, h, pa); check("R6 slot0 kept", pa, 32'hC000_0ABC);
        look(32'h0001_F123, h, pa); check("R6 last slot kept", pa, 32'hC001_F123);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule